// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Standby Control

This block drives and observes a bank of general-purpose pins. Software reaches it over a small register bus. It has three registers: an output data latch, a per-bit direction register, and a read-only port view. In the port view, output bits show the latch and input bits show the pin level after synchronisation. The output latch drives the pin outputs at all times, and each pin's output enable follows its direction bit.

Two power-state inputs change the port's behaviour. Hardware standby clears the latch and the direction register and drops every output enable, so all pins become inputs. Software standby freezes the port. Bus writes are ignored and both writable registers keep their contents. The port view keeps the value it held before standby, even if pins toggle. If both inputs are high, hardware standby wins.

Top module: `gpio_port`

## Requirements
- R1: After reset the data and direction registers read 0x00, `pin_out` and `pin_oe` are 0x00, and the port view (offset 2) returns the synchronised pin levels.
- R2: A write to offset 0 loads the output data register. The same value reads back from offset 0 and appears on `pin_out` after the write edge.
- R3: A write to offset 1 loads the direction register, which reads back from offset 1. Outside hardware standby, `pin_oe` equals the direction register (1 = output).
- R4: A read of offset 2 returns, per bit, the data register bit where the direction bit is 1 and the synchronised pin bit where it is 0.
- R5: A pin change reaches the port view after exactly two rising clock edges. After one edge the old value is still returned.
- R6: A write to offset 2 changes no state. Offsets 0, 1 and 2 read the same values before and after it.
- R7: A read of offset 3 returns 0x00. While `bus_rd_en` is low, `bus_rd_data` is 0x00.
- R8: While `hw_stby` is high, `pin_oe` is 0x00 in the same cycle. The data and direction registers are 0x00 from the next edge on, bus writes are ignored, and the port view returns the synchronised pins.
- R9: While `sw_stby` is high (and `hw_stby` is low), bus writes are ignored. The data and direction registers keep their values. The port view returns the value it had in the cycle before standby began, whatever the pins do.
- R10: When `hw_stby` and `sw_stby` are both high, the hardware standby behaviour of R8 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: clears the port |
| sw_stby | input | 1 | Software standby: freezes the port |
| bus_addr | input | 2 | Register offset (0 data, 1 direction, 2 port view) |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 8 | Read data (combinational from current state) |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pin_out | output | 8 | Output data to the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A corrupted data or direction bit shows at once on `pin_out` or `pin_oe`. It also shows in the same cycle in any read of offsets 0, 1 or 2, so the bench compares those after every scenario. A wrong synchroniser depth shifts the moment a pin change becomes visible by one edge, so the bench samples the port view one edge and two edges after a pin change. A frozen view that was not held, or was captured at the wrong moment, shows as soon as pins toggle during software standby. A standby clear or freeze that is missing shows in the first read after the standby window.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PORT = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

    // R5: the output is the input delayed by exactly STAGES edges (two by default)
    if (STAGES == 2) begin : g_chk
        p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> dout == $past(din, 2));
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      data_o,
    output logic [WIDTH-1:0]      dir_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw_stby) begin
            st_d = '0;
        end else if (!sw_stby && wr_en) begin
            case (reg_sel_e'(addr))
                SEL_DATA: st_d.data = wr_data;
                SEL_DIR:  st_d.dir  = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign dir_o  = st_q.dir;

    // R8: hardware standby clears both registers at the next edge
    p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (st_q.data == '0) && (st_q.dir == '0));
    // R9: software standby freezes both registers
    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(st_q));
    // R2: an accepted data write lands in the latch
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ADDR_W'(SEL_DATA) && !hw_stby && !sw_stby)
            |=> st_q.data == $past(wr_data));
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  rd_en,
    input  logic [WIDTH-1:0]      data_i,
    input  logic [WIDTH-1:0]      dir_i,
    input  logic [WIDTH-1:0]      pins_sync,
    output logic [WIDTH-1:0]      rd_data
);
    logic [WIDTH-1:0] view_d, view_q;
    logic [WIDTH-1:0] live_view, port_val;
    logic             frozen;

    always_comb begin
        frozen    = sw_stby && !hw_stby;
        live_view = hw_stby ? pins_sync : ((dir_i & data_i) | (~dir_i & pins_sync));
        view_d    = frozen ? view_q : live_view;
        port_val  = frozen ? view_q : live_view;
        rd_data   = '0;
        if (rd_en) begin
            case (reg_sel_e'(addr))
                SEL_DATA: rd_data = data_i;
                SEL_DIR:  rd_data = dir_i;
                SEL_PORT: rd_data = port_val;
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) view_q <= '0;
        else        view_q <= view_d;
    end

    // R9: the captured view stays put during software standby
    p_view_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> (!(sw_stby && !hw_stby)) || $stable(view_q));
    // R7: unmapped offset and idle bus read as zero
    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || addr == 2'd3) |-> rd_data == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr_en,
    input  logic [WIDTH-1:0]      bus_wr_data,
    input  logic                  bus_rd_en,
    output logic [WIDTH-1:0]      bus_rd_data,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pin_out,
    output logic [WIDTH-1:0]      pin_oe
);
    logic [WIDTH-1:0] data_w, dir_w, pins_sync_w;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_sync_w)
    );

    gpio_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .addr(bus_addr), .wr_en(bus_wr_en), .wr_data(bus_wr_data),
        .data_o(data_w), .dir_o(dir_w)
    );

    gpio_readmux #(.WIDTH(WIDTH)) rmux_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .addr(bus_addr), .rd_en(bus_rd_en), .data_i(data_w), .dir_i(dir_w),
        .pins_sync(pins_sync_w), .rd_data(bus_rd_data)
    );

    assign pin_out = data_w;
    assign pin_oe  = hw_stby ? '0 : dir_w;

    // R8: no pin is driven during hardware standby
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> pin_oe == '0);
    // R3: an enabled output always belongs to a direction bit set to 1
    p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == REG_ADDR_W'(SEL_DIR) && !hw_stby) |-> pin_oe == bus_rd_data);
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       hw_stby = 0, sw_stby = 0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr_en = 0, bus_rd_en = 0;
    logic [7:0] bus_wr_data = '0, pin_in = '0;
    logic [7:0] bus_rd_data, pin_out, pin_oe;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1;
        #1 d = bus_rd_data;
        bus_rd_en = 0;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(0, v); check("R1", "data after reset", v, 8'h00);
        bus_read(1, v); check("R1", "dir after reset", v, 8'h00);
        check("R1", "pin_out after reset", pin_out, 8'h00);
        check("R1", "pin_oe after reset", pin_oe, 8'h00);
        bus_read(2, v); check("R1", "port view = pins", v, 8'hA5);
    endtask

    task automatic t_data();
        logic [7:0] v;
        bus_write(0, 8'h3C);
        bus_read(0, v); check("R2", "data readback", v, 8'h3C);
        check("R2", "pin_out", pin_out, 8'h3C);
        bus_write(0, 8'hFF);
        check("R2", "pin_out all ones", pin_out, 8'hFF);
        bus_write(0, 8'h3C);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        bus_write(1, 8'h0F);
        bus_read(1, v); check("R3", "dir readback", v, 8'h0F);
        check("R3", "pin_oe follows dir", pin_oe, 8'h0F);
    endtask

    task automatic t_mix();
        logic [7:0] v;
        bus_read(2, v); check("R4", "mix dir=0F", v, 8'hAC);
        bus_write(1, 8'hF0);
        bus_read(2, v); check("R4", "mix dir=F0", v, 8'h35);
        bus_write(1, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h5A;
        @(posedge clk); #1; bus_addr = 2; bus_rd_en = 1;
        #1 check("R5", "one edge after pin change", bus_rd_data, 8'hA5);
        @(posedge clk); #1;
        check("R5", "two edges after pin change", bus_rd_data, 8'h5A);
        bus_rd_en = 0;
        set_pins(8'hA5);
        bus_read(2, v); check("R5", "settled again", v, 8'hA5);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        bus_write(0, 8'h12); bus_write(1, 8'h0F);
        bus_write(2, 8'h77);
        bus_read(0, v); check("R6", "data after port write", v, 8'h12);
        bus_read(1, v); check("R6", "dir after port write", v, 8'h0F);
        bus_read(2, v); check("R6", "view after port write", v, 8'hA2);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        bus_read(3, v); check("R7", "offset 3", v, 8'h00);
        @(negedge clk); bus_addr = 0; bus_rd_en = 0;
        #1 check("R7", "idle read data", bus_rd_data, 8'h00);
    endtask

    task automatic t_hw();
        logic [7:0] v;
        bus_write(0, 8'h3C); bus_write(1, 8'hFF);
        @(negedge clk); hw_stby = 1;
        #1 check("R8", "oe dropped same cycle", pin_oe, 8'h00);
        bus_write(0, 8'h99);
        bus_read(2, v); check("R8", "view during hw standby", v, 8'hA5);
        @(negedge clk); hw_stby = 0;
        bus_read(0, v); check("R8", "data cleared", v, 8'h00);
        bus_read(1, v); check("R8", "dir cleared", v, 8'h00);
    endtask

    task automatic t_sw();
        logic [7:0] v;
        bus_write(0, 8'h12); bus_write(1, 8'h0F);
        set_pins(8'hA0);
        bus_read(2, v); check("R9", "view before standby", v, 8'hA2);
        @(negedge clk); sw_stby = 1;
        bus_write(0, 8'h55); bus_write(1, 8'hF0);
        set_pins(8'h50);
        bus_read(2, v); check("R9", "frozen view", v, 8'hA2);
        bus_read(0, v); check("R9", "data held", v, 8'h12);
        bus_read(1, v); check("R9", "dir held", v, 8'h0F);
        @(negedge clk); sw_stby = 0;
        bus_read(2, v); check("R9", "view after release", v, 8'h52);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        @(negedge clk); sw_stby = 1; hw_stby = 1;
        #1 check("R10", "oe low with both", pin_oe, 8'h00);
        repeat (2) @(negedge clk);
        sw_stby = 0; hw_stby = 0;
        bus_read(0, v); check("R10", "data cleared with both", v, 8'h00);
        bus_read(1, v); check("R10", "dir cleared with both", v, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reset();
        t_data();
        t_dir();
        t_mix();
        t_sync();
        t_readonly();
        t_unmapped();
        t_hw();
        t_sw();
        t_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule